// File: doc/BRIEF.md
# Framed Packet SPI Transmitter

This block moves one variable-length block of already-compressed bytes to a radio transceiver over an SPI master link. Each block goes out as a frame. The frame opens with a fixed sync byte, so that a receiver that has lost its place can find the next frame boundary. A 16-bit byte count follows the sync byte, and then the payload bytes.

The producer upstream requests a frame with a single-cycle start pulse and the payload length. It then supplies the payload bytes one at a time through a valid/ready handshake. The block takes one payload byte each time the serialiser becomes free, so the producer can run ahead or lag behind. If the producer falls behind, the link simply pauses with the serial clock held low.

Top module: `fsp_framer_tx`

## Requirements
- R1: After reset, chip select (`cs_n_o`) is high, `sclk_o` is low, `busy_o` is low and `pay_ready_o` is low.
- R2: The first byte shifted out after an accepted start is the sync value 0xAA.
- R3: The two bytes after the sync byte carry the 16-bit length captured at start, high byte first, then low byte.
- R4: After the length, exactly as many payload bytes are shifted out as the length says, in handshake order. Every byte is sent most significant bit first.
- R5: SPI mode 0: `sclk_o` idles low, the receiver samples `mosi_o` on the rising edge, and every high phase of `sclk_o` lasts exactly `HALF_DIV` system clocks.
- R6: `cs_n_o` is low from the cycle after an accepted start until the last bit of the frame has completed, and `sclk_o` never rises while `cs_n_o` is high.
- R7: `busy_o` is high from the cycle after an accepted start until the final byte has fully shifted out. It then falls in the same cycle that `cs_n_o` rises.
- R8: A start pulse seen while `busy_o` is high is ignored. The frame in progress keeps its length and contents, and no second frame follows it.
- R9: When `pay_ready_o` is high and `pay_valid_i` is low, the link stalls: `sclk_o` stays low and `cs_n_o` stays low.
- R10: `pay_ready_o` is only high during the payload phase of a frame, and each byte transfer takes one cycle with both valid and ready high.
- R11: A frame of length 0 consists of the sync byte and two length bytes only, and `pay_ready_o` is never raised for it.
- R12: `mosi_o` does not change while `sclk_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to send a frame |
| len_i | input | 16 | Payload byte count, captured with the start request |
| pay_data_i | input | 8 | Payload byte from the producer |
| pay_valid_i | input | 1 | Producer has a byte on `pay_data_i` |
| pay_ready_o | output | 1 | Block takes the byte this cycle if valid is high |
| busy_o | output | 1 | A frame is in progress |
| sclk_o | output | 1 | SPI serial clock, mode 0 |
| mosi_o | output | 1 | SPI serial data out |
| cs_n_o | output | 1 | SPI chip select, active low |

## Verification
The assertions check, on every cycle:
- data stays stable while the serial clock is high;
- the clock rises only under chip select;
- the ready signal appears only inside a frame;
- the clock stays quiet while a ready byte is missing;
- the captured length is frozen while busy;
- the payload counter never sits at zero in the payload phase.

Only the bench scenarios can show the rest. They rebuild every byte at the serial pins and check the byte order, that the length is sent high byte first, and the exact width of each clock high phase. They also cover the zero-length frame, a frame whose length needs the high byte, payload stalls, and that a start pulse arriving mid-frame produces no second frame.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    localparam int unsigned FSP_LEN_W  = 16;
    localparam int unsigned FSP_BYTE_W = 8;
    localparam int unsigned FSP_BIT_W  = $clog2(FSP_BYTE_W);
    localparam logic [FSP_BYTE_W-1:0] FSP_SYNC_BYTE = 8'hAA;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MARK,
        ST_LENH,
        ST_LENL,
        ST_PAY,
        ST_TAIL
    } fsp_state_e;

    typedef struct packed {
        fsp_state_e           st;
        logic [FSP_LEN_W-1:0] len;
        logic [FSP_LEN_W-1:0] rem;
    } fsp_seq_t;

    typedef struct packed {
        logic                  active;
        logic                  sclk;
        logic [FSP_BIT_W-1:0]  nbit;
        logic [FSP_BYTE_W-1:0] sh;
    } fsp_shift_t;

endpackage

// File: rtl/fsp_pace.sv
module fsp_pace #(
    parameter int unsigned LIMIT = 2,
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(LIMIT - 1));
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R5: the half-period counter stays inside its window
    assert_pace_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) < LIMIT);

endmodule

// File: rtl/fsp_shifter.sv
module fsp_shifter
    import fsp_pkg::*;
#(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_valid,
    input  logic [FSP_BYTE_W-1:0] ld_byte,
    output logic                  ld_ready,
    output logic                  sclk,
    output logic                  mosi
);

    fsp_shift_t r_d, r_q;
    logic       half_tick;

    fsp_pace #(.LIMIT(HALF_DIV)) u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.active),
        .tick  (half_tick)
    );

    always_comb begin
        r_d      = r_q;
        ld_ready = !r_q.active;
        if (!r_q.active) begin
            if (ld_valid) begin
                r_d.active = 1'b1;
                r_d.sclk   = 1'b0;
                r_d.nbit   = '0;
                r_d.sh     = ld_byte;
            end
        end else if (half_tick) begin
            if (!r_q.sclk) begin
                r_d.sclk = 1'b1;
            end else begin
                r_d.sclk = 1'b0;
                r_d.sh   = {r_q.sh[FSP_BYTE_W-2:0], 1'b0};
                if (r_q.nbit == FSP_BIT_W'(FSP_BYTE_W - 1)) begin
                    r_d.active = 1'b0;
                end else begin
                    r_d.nbit = r_q.nbit + FSP_BIT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sclk = r_q.sclk;
    assign mosi = r_q.sh[FSP_BYTE_W-1];

    // R12: data bit held while the clock is high
    assert_mosi_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.sclk && $past(r_q.sclk)) |-> $stable(r_q.sh[FSP_BYTE_W-1]));

endmodule

// File: rtl/fsp_framer_tx.sv
module fsp_framer_tx
    import fsp_pkg::*;
#(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [FSP_LEN_W-1:0]  len_i,
    input  logic [FSP_BYTE_W-1:0] pay_data_i,
    input  logic                  pay_valid_i,
    output logic                  pay_ready_o,
    output logic                  busy_o,
    output logic                  sclk_o,
    output logic                  mosi_o,
    output logic                  cs_n_o
);

    fsp_seq_t              s_d, s_q;
    logic                  ld_valid;
    logic                  ld_ready;
    logic [FSP_BYTE_W-1:0] ld_byte;

    fsp_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_byte  (ld_byte),
        .ld_ready (ld_ready),
        .sclk     (sclk_o),
        .mosi     (mosi_o)
    );

    always_comb begin
        s_d         = s_q;
        ld_valid    = 1'b0;
        ld_byte     = '0;
        pay_ready_o = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.len = len_i;
                    s_d.rem = len_i;
                    s_d.st  = ST_MARK;
                end
            end
            ST_MARK: begin
                ld_valid = 1'b1;
                ld_byte  = FSP_SYNC_BYTE;
                if (ld_ready) s_d.st = ST_LENH;
            end
            ST_LENH: begin
                ld_valid = 1'b1;
                ld_byte  = s_q.len[FSP_LEN_W-1 -: FSP_BYTE_W];
                if (ld_ready) s_d.st = ST_LENL;
            end
            ST_LENL: begin
                ld_valid = 1'b1;
                ld_byte  = s_q.len[FSP_BYTE_W-1:0];
                if (ld_ready) begin
                    s_d.st = (s_q.len == '0) ? ST_TAIL : ST_PAY;
                end
            end
            ST_PAY: begin
                pay_ready_o = ld_ready;
                ld_valid    = pay_valid_i;
                ld_byte     = pay_data_i;
                if (ld_ready && pay_valid_i) begin
                    s_d.rem = s_q.rem - FSP_LEN_W'(1);
                    if (s_q.rem == FSP_LEN_W'(1)) s_d.st = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (ld_ready) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, len: '0, rem: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = (s_q.st != ST_IDLE);
    assign cs_n_o = (s_q.st == ST_IDLE);

    // R6: serial clock only rises inside a selected frame
    assert_sclk_framed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> !cs_n_o);

    // R10: ready only inside a frame
    assert_ready_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready_o |-> (busy_o && !cs_n_o));

    // R9: missing payload byte keeps the clock low
    assert_stall_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_ready_o && !pay_valid_i) |=> (!sclk_o && !cs_n_o));

    // R8: a start during a frame leaves the captured length alone
    assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(s_q.len));

    // R4: payload phase always has bytes still owed
    assert_rem_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_PAY) |-> (s_q.rem != '0));

endmodule

// File: tb/fsp_framer_tx_test.sv
module fsp_framer_tx_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] len_i = '0;
    logic [7:0]  pay_data_i = '0;
    logic        pay_valid_i = 1'b0;
    logic        pay_ready_o, busy_o, sclk_o, mosi_o, cs_n_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    logic       sclk_prev = 1'b0;
    logic [7:0] acc = '0;
    int         bit_n = 0;
    int         hi_cnt = 0;
    int         ready_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsp_framer_tx #(.HALF_DIV(HALF)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .len_i       (len_i),
        .pay_data_i  (pay_data_i),
        .pay_valid_i (pay_valid_i),
        .pay_ready_o (pay_ready_o),
        .busy_o      (busy_o),
        .sclk_o      (sclk_o),
        .mosi_o      (mosi_o),
        .cs_n_o      (cs_n_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: rebuild bytes at the pins and compare with the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (pay_ready_o) ready_cnt++;
            if (sclk_o && !sclk_prev) begin
                chk(!cs_n_o, "R6 sclk rise under cs", int'(cs_n_o), 0);
                acc = {acc[6:0], mosi_o};
                bit_n++;
                hi_cnt = 0;
                if (bit_n == 8) begin
                    bit_n = 0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8 unexpected byte", int'(acc), -1);
                    end else begin
                        int    e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        chk(int'(acc) == e, t, int'(acc), e);
                    end
                end
            end
            if (sclk_o) hi_cnt++;
            if (!sclk_o && sclk_prev) begin
                chk(hi_cnt == HALF, "R5 sclk high width", hi_cnt, HALF);
            end
            sclk_prev = sclk_o;
        end
    end

    task automatic push(input int b, input string t);
        exp_q.push_back(b);
        tag_q.push_back(t);
    endtask

    task automatic send_frame(input int len, input int stall, input bit poke);
        push(8'hAA, "R2 sync byte");
        push((len >> 8) & 8'hFF, "R3 length high byte");
        push(len & 8'hFF, "R3 length low byte");
        for (int i = 0; i < len; i++) push((i * 7 + len) & 8'hFF, "R4 payload byte");
        ready_cnt = 0;
        @(negedge clk);
        start_i = 1'b1;
        len_i   = 16'(len);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R7 busy after start", int'(busy_o), 1);
        chk(cs_n_o == 1'b0, "R6 cs low after start", int'(cs_n_o), 0);
        for (int i = 0; i < len; i++) begin
            if (poke && i == 2) begin
                start_i = 1'b1;
                len_i   = 16'd2;
                @(negedge clk);
                start_i = 1'b0;
            end
            if (stall > 0) begin
                while (!pay_ready_o) @(negedge clk);
                for (int s = 0; s < stall; s++) begin
                    @(negedge clk);
                    chk(!sclk_o && !cs_n_o, "R9 stall keeps sclk low",
                        int'(sclk_o), 0);
                end
            end
            pay_data_i  = 8'((i * 7 + len) & 8'hFF);
            pay_valid_i = 1'b1;
            while (!pay_ready_o) @(negedge clk);
            @(negedge clk);
            pay_valid_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        chk(cs_n_o == 1'b1, "R7 cs high when busy falls", int'(cs_n_o), 1);
        chk(exp_q.size() == 0, "R4 all bytes shifted", exp_q.size(), 0);
        chk(bit_n == 0, "R4 whole bytes only", bit_n, 0);
        if (len == 0) chk(ready_cnt == 0, "R11 no ready for empty frame", ready_cnt, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n_o == 1'b1, "R1 reset cs", int'(cs_n_o), 1);
        chk(sclk_o == 1'b0, "R1 reset sclk", int'(sclk_o), 0);
        chk(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);
        chk(pay_ready_o == 1'b0, "R1 reset ready", int'(pay_ready_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        send_frame(5, 0, 1'b0);
        send_frame(4, 3, 1'b0);
        send_frame(0, 0, 1'b0);
        send_frame(1, 1, 1'b0);
        send_frame(6, 0, 1'b1);
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (k % 25 == 0)
                chk(cs_n_o && !busy_o, "R8 no second frame", int'(busy_o), 0);
        end
        send_frame(300, 0, 1'b0);
        repeat (5) @(negedge clk);
        chk(pay_ready_o == 1'b0, "R10 ready idle after frame", int'(pay_ready_o), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule